// File: doc/BRIEF.md
# Multicycle instruction sequencing core

This block steps a non-pipelined 32-bit load/store processor through one register-transfer step per clock. A state machine decodes the fetched instruction word and fans out into a separate short sequence for each instruction class. The classes are register-register arithmetic, register-immediate arithmetic, load, store, conditional branch and jump. Every sequence returns to the fetch step when it ends. The controller sets the control points of a small datapath held in the same block: the instruction, program-counter, operand, result and write-back registers, the register-file write port, the memory strobes and the operand and address selects.

A single word-addressed memory port serves both instruction fetch and data access. The port reads combinationally and writes on the clock edge. A qualifier marks the accesses that are instruction fetches. The number of cycles each instruction takes depends only on its class, so the cost of a program is known in advance.

Top module: `mcc_core`

## Requirements
- R1: Each instruction begins with a fetch cycle. In that cycle `mem_rd` and `mem_ifetch` are high and `mem_addr` equals PC. The word read is latched as the instruction and PC advances by 4. The following instruction is fetched at that PC unless a branch or jump changes it.
- R2: Instruction fields sit at fixed positions. The opcode is in bits 31:26 and rs in 25:21. rt is in 20:16 and rd in 15:11. The function code is in 5:0, the immediate in 15:0 and the jump target in 25:0. The latched instruction changes only in a fetch cycle.
- R3: Opcode 0x00 is a register-register operation. The function code selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, and 0x2A signed less-than, which gives 1 or 0. The operands are rs and rt and the result goes to rd. The instruction takes 5 cycles.
- R4: Opcodes 0x08 add, 0x0C and, 0x0D or and 0x0E xor combine rs with the sign-extended 16-bit immediate. The result goes to rt. The instruction takes 5 cycles.
- R5: Opcode 0x23 loads the memory word at rs plus the sign-extended immediate into rt. The instruction takes 5 cycles.
- R6: Opcode 0x2B writes rt to memory at rs plus the sign-extended immediate. The instruction takes 4 cycles.
- R7: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. A taken branch sets PC to the address of the following instruction plus the sign-extended immediate, as a byte offset. A branch takes 3 cycles whether or not it is taken.
- R8: Opcode 0x02 sets PC to the upper 4 bits of the incremented PC, followed by the 26-bit target and two zero bits. The instruction takes 3 cycles.
- R9: Register 0 always reads as zero, and a write to it is ignored.
- R10: An undefined opcode returns to fetch after 2 cycles and changes no register or memory word. The next fetch is at the sequential address.
- R11: While `rst` is high at a clock edge the controller is forced into the fetch step with PC at 0. After reset, the first fetch is at address 0.
- R12: `mem_rd` and `mem_wr` are never high together, and `mem_ifetch` is only high while `mem_rd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address of the current memory access |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_ifetch | output | 1 | Current read is an instruction fetch |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |

## Verification
One program covers every instruction class, and the values it stores show which operation, operand source and destination field each class used. Negative immediates and a signed compare separate sign extension and signed arithmetic from their unsigned versions. Memory words preset to marker values show whether instructions skipped by a taken branch or a jump ran, and whether a write to register 0 had any effect. The spacing between logged fetches, and their addresses, give each class's cycle count and next-PC rule, including the not-taken branch and the undefined opcode.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;

   typedef enum logic [3:0] {
      S_FETCH, S_DECODE, S_RR_EXE, S_RI_EXE, S_RES_WB, S_REG_WR,
      S_LD_ADDR, S_LD_MEM, S_ST_ADDR, S_ST_MEM, S_BRANCH, S_JUMP
   } state_t;

   typedef enum logic [2:0] {C_RR, C_RI, C_LD, C_ST, C_BR, C_JMP, C_BAD} iclass_t;

   typedef enum logic [2:0] {A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_SLT} aluop_t;

   localparam logic [5:0] OP_RR   = 6'h00;
   localparam logic [5:0] OP_J    = 6'h02;
   localparam logic [5:0] OP_BEQ  = 6'h04;
   localparam logic [5:0] OP_BNE  = 6'h05;
   localparam logic [5:0] OP_ADDI = 6'h08;
   localparam logic [5:0] OP_ANDI = 6'h0C;
   localparam logic [5:0] OP_ORI  = 6'h0D;
   localparam logic [5:0] OP_XORI = 6'h0E;
   localparam logic [5:0] OP_LW   = 6'h23;
   localparam logic [5:0] OP_SW   = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_XOR = 6'h26;
   localparam logic [5:0] FN_SLT = 6'h2A;

   // One bit per control point of the datapath
   typedef struct packed {
      logic   ir_ld;
      logic   pc_inc;
      logic   pc_br;
      logic   pc_jmp;
      logic   ab_ld;
      logic   res_ld;
      logic   src_imm;
      logic   wb_ld;
      logic   wb_from_mem;
      logic   rf_we;
      logic   dst_rt;
      logic   mem_rd;
      logic   mem_wr;
      logic   addr_res;
      logic   ifetch;
      aluop_t alu_op;
   } ctrl_t;

endpackage

// File: rtl/mcc_decode.sv
`timescale 1ns/1ps
module mcc_decode
   import mcc_pkg::*;
#(
   parameter bit SLT_EN = 1'b1
) (
   input  logic [5:0] op,
   input  logic [5:0] funct,
   output iclass_t    iclass,
   output aluop_t     alu_op
);

   always_comb begin
      iclass = C_BAD;
      alu_op = A_ADD;
      case (op)
         OP_RR: begin
            iclass = C_RR;
            case (funct)
               FN_ADD:  alu_op = A_ADD;
               FN_SUB:  alu_op = A_SUB;
               FN_AND:  alu_op = A_AND;
               FN_OR:   alu_op = A_OR;
               FN_XOR:  alu_op = A_XOR;
               FN_SLT: begin
                  alu_op = A_SLT;
                  if (!SLT_EN) iclass = C_BAD;
               end
               default: iclass = C_BAD;
            endcase
         end
         OP_ADDI: begin iclass = C_RI; alu_op = A_ADD; end
         OP_ANDI: begin iclass = C_RI; alu_op = A_AND; end
         OP_ORI:  begin iclass = C_RI; alu_op = A_OR;  end
         OP_XORI: begin iclass = C_RI; alu_op = A_XOR; end
         OP_LW:   iclass = C_LD;
         OP_SW:   iclass = C_ST;
         OP_BEQ, OP_BNE: iclass = C_BR;
         OP_J:    iclass = C_JMP;
         default: iclass = C_BAD;
      endcase
   end

endmodule

// File: rtl/mcc_alu.sv
`timescale 1ns/1ps
module mcc_alu
   import mcc_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter bit SLT_EN = 1'b1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  aluop_t          op,
   output logic [XLEN-1:0] y
);

   logic [XLEN-1:0] lt_word;

   generate
      if (SLT_EN) begin : g_slt
         assign lt_word = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      end else begin : g_no_slt
         assign lt_word = '0;
      end
   endgenerate

   always_comb begin
      case (op)
         A_ADD:   y = a + b;
         A_SUB:   y = a - b;
         A_AND:   y = a & b;
         A_OR:    y = a | b;
         A_XOR:   y = a ^ b;
         A_SLT:   y = lt_word;
         default: y = a + b;
      endcase
   end

endmodule

// File: rtl/mcc_regfile.sv
`timescale 1ns/1ps
module mcc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   input  logic [AW-1:0]   ra,
   input  logic [AW-1:0]   rb,
   output logic [XLEN-1:0] qa,
   output logic [XLEN-1:0] qb
);

   logic [XLEN-1:0] bank [NREG];

   // Slot 0 has no storage: it is a constant zero
   assign bank[0] = '0;

   generate
      for (genvar g = 1; g < NREG; g++) begin : g_slot
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (we && (wa == AW'(g))) q <= wd;
         end
         assign bank[g] = q;
      end
   endgenerate

   assign qa = bank[ra];
   assign qb = bank[rb];

endmodule

// File: rtl/mcc_ctrl.sv
`timescale 1ns/1ps
module mcc_ctrl
   import mcc_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  iclass_t iclass,
   input  aluop_t  alu_sel,
   input  logic    br_ok,
   output ctrl_t   cp,
   output state_t  state_o
);

   state_t st, nxt;

   always_ff @(posedge clk) begin
      if (rst) st <= S_FETCH;
      else     st <= nxt;
   end

   assign state_o = st;

   always_comb begin
      cp        = '0;
      cp.alu_op = alu_sel;
      nxt       = S_FETCH;
      case (st)
         S_FETCH: begin
            cp.ir_ld  = 1'b1;
            cp.pc_inc = 1'b1;
            cp.mem_rd = 1'b1;
            cp.ifetch = 1'b1;
            nxt       = S_DECODE;
         end
         S_DECODE: begin
            cp.ab_ld = 1'b1;
            case (iclass)
               C_RR:    nxt = S_RR_EXE;
               C_RI:    nxt = S_RI_EXE;
               C_LD:    nxt = S_LD_ADDR;
               C_ST:    nxt = S_ST_ADDR;
               C_BR:    nxt = S_BRANCH;
               C_JMP:   nxt = S_JUMP;
               default: nxt = S_FETCH;
            endcase
         end
         S_RR_EXE: begin
            cp.res_ld = 1'b1;
            nxt       = S_RES_WB;
         end
         S_RI_EXE: begin
            cp.res_ld  = 1'b1;
            cp.src_imm = 1'b1;
            nxt        = S_RES_WB;
         end
         S_RES_WB: begin
            cp.wb_ld = 1'b1;
            nxt      = S_REG_WR;
         end
         S_REG_WR: begin
            cp.rf_we  = 1'b1;
            cp.dst_rt = (iclass != C_RR);
            nxt       = S_FETCH;
         end
         S_LD_ADDR, S_ST_ADDR: begin
            cp.res_ld  = 1'b1;
            cp.src_imm = 1'b1;
            cp.alu_op  = A_ADD;
            nxt        = (st == S_LD_ADDR) ? S_LD_MEM : S_ST_MEM;
         end
         S_LD_MEM: begin
            cp.mem_rd      = 1'b1;
            cp.addr_res    = 1'b1;
            cp.wb_ld       = 1'b1;
            cp.wb_from_mem = 1'b1;
            nxt            = S_REG_WR;
         end
         S_ST_MEM: begin
            cp.mem_wr   = 1'b1;
            cp.addr_res = 1'b1;
            nxt         = S_FETCH;
         end
         S_BRANCH: begin
            cp.pc_br = br_ok;
            nxt      = S_FETCH;
         end
         S_JUMP: begin
            cp.pc_jmp = 1'b1;
            nxt       = S_FETCH;
         end
         default: nxt = S_FETCH;
      endcase
   end

   assert_decode_follows_fetch_R1: assert property (@(posedge clk) disable iff (rst)
      (st == S_FETCH) |=> (st == S_DECODE));

   assert_undefined_returns_R10: assert property (@(posedge clk) disable iff (rst)
      (st == S_DECODE && iclass == C_BAD) |=> (st == S_FETCH));

   assert_store_returns_R6: assert property (@(posedge clk) disable iff (rst)
      (st == S_ST_MEM) |=> (st == S_FETCH));

endmodule

// File: rtl/mcc_core.sv
`timescale 1ns/1ps
module mcc_core
   import mcc_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          NREG     = 32,
   parameter bit          SLT_EN   = 1'b1,
   parameter logic [31:0] PC_RESET = 32'h0
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] mem_addr,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic            mem_ifetch,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata
);

   localparam int AW     = $clog2(NREG);
   localparam int IMMW   = 16;
   localparam int JTW    = 26;
   localparam int PCHI   = XLEN - JTW - 2;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mcc_core: instruction fields require XLEN of 32");
      end
      if (NREG < 2 || NREG > 32 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("mcc_core: NREG must be a power of two from 2 to 32");
      end
   endgenerate

   logic [XLEN-1:0] ir, pc, a_q, b_q, res_q, wb_q;
   logic [XLEN-1:0] rf_a, rf_b, alu_b, alu_y, simm;
   logic [5:0]      op_f, fn_f;
   logic [4:0]      rs_f, rt_f, rd_f;
   logic            br_ok;
   iclass_t         iclass;
   aluop_t          alu_sel;
   ctrl_t           cp;
   state_t          st;

   assign op_f = ir[31:26];
   assign rs_f = ir[25:21];
   assign rt_f = ir[20:16];
   assign rd_f = ir[15:11];
   assign fn_f = ir[5:0];
   assign simm = {{(XLEN-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]};

   mcc_decode #(.SLT_EN(SLT_EN)) u_decode (
      .op(op_f), .funct(fn_f), .iclass(iclass), .alu_op(alu_sel)
   );

   mcc_ctrl u_ctrl (
      .clk(clk), .rst(rst), .iclass(iclass), .alu_sel(alu_sel),
      .br_ok(br_ok), .cp(cp), .state_o(st)
   );

   mcc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk(clk), .we(cp.rf_we),
      .wa(cp.dst_rt ? AW'(rt_f) : AW'(rd_f)), .wd(wb_q),
      .ra(AW'(rs_f)), .rb(AW'(rt_f)), .qa(rf_a), .qb(rf_b)
   );

   assign alu_b = cp.src_imm ? simm : b_q;

   mcc_alu #(.XLEN(XLEN), .SLT_EN(SLT_EN)) u_alu (
      .a(a_q), .b(alu_b), .op(cp.alu_op), .y(alu_y)
   );

   assign br_ok = (op_f == OP_BNE) ? (a_q != b_q) : (a_q == b_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc    <= XLEN'(PC_RESET);
         ir    <= '0;
         a_q   <= '0;
         b_q   <= '0;
         res_q <= '0;
         wb_q  <= '0;
      end else begin
         if (cp.ir_ld) ir <= mem_rdata;
         if (cp.pc_inc)      pc <= pc + XLEN'(4);
         else if (cp.pc_br)  pc <= pc + simm;
         else if (cp.pc_jmp) pc <= {pc[XLEN-1 -: PCHI], ir[JTW-1:0], 2'b00};
         if (cp.ab_ld) begin
            a_q <= rf_a;
            b_q <= rf_b;
         end
         if (cp.res_ld) res_q <= alu_y;
         if (cp.wb_ld)  wb_q  <= cp.wb_from_mem ? mem_rdata : res_q;
      end
   end

   assign mem_addr   = cp.addr_res ? res_q : pc;
   assign mem_rd     = cp.mem_rd;
   assign mem_wr     = cp.mem_wr;
   assign mem_ifetch = cp.ifetch;
   assign mem_wdata  = b_q;

   assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
      mem_ifetch |=> (pc == $past(pc) + XLEN'(4)));

   assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !mem_ifetch |=> $stable(ir));

   assert_no_rd_wr_R12: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   assert_fetch_is_read_R12: assert property (@(posedge clk) disable iff (rst)
      mem_ifetch |-> (mem_rd && mem_addr == pc));

   assert_jump_only_pc_R8: assert property (@(posedge clk) disable iff (rst)
      (st == S_JUMP) |=> ($stable(a_q) && $stable(b_q) && $stable(wb_q)));

endmodule

// File: tb/test_mcc_core.sv
`timescale 1ns/1ps
module test_mcc_core;

   localparam int PERIOD = 20;
   localparam int MWORDS = 256;
   localparam int NLOG   = 64;

   function automatic logic [31:0] ei(input logic [5:0] op, input int rs, input int rt, input int im);
      return {op, 5'(rs), 5'(rt), 16'(im)};
   endfunction
   function automatic logic [31:0] er(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] ej(input int t);
      return {6'h02, 26'(t)};
   endfunction

   localparam int NPROG = 28;
   localparam logic [31:0] PROG [NPROG] = '{
      ei(6'h08, 0, 1, 5),        // 0  r1 = 5
      ei(6'h08, 0, 2, -3),       // 1  r2 = -3
      er(1, 2, 3, 6'h20),        // 2  r3 = r1 + r2
      er(1, 2, 4, 6'h22),        // 3  r4 = r1 - r2
      ei(6'h2B, 0, 3, 'h100),    // 4
      ei(6'h2B, 0, 4, 'h104),    // 5
      ei(6'h0D, 0, 5, 'hF0),     // 6  r5 = 0xF0
      er(5, 1, 6, 6'h26),        // 7  r6 = r5 ^ r1
      ei(6'h2B, 0, 6, 'h108),    // 8
      ei(6'h23, 0, 7, 'h104),    // 9  r7 = mem[0x104]
      er(7, 1, 8, 6'h25),        // 10 r8 = r7 | r1
      er(2, 1, 9, 6'h2A),        // 11 r9 = (r2 < r1) signed
      ei(6'h2B, 0, 8, 'h10C),    // 12
      ei(6'h2B, 0, 9, 'h110),    // 13
      ei(6'h08, 1, 0, 7),        // 14 write to r0
      ei(6'h2B, 0, 0, 'h114),    // 15
      ei(6'h04, 1, 1, 8),        // 16 taken, to word 19
      ei(6'h2B, 0, 1, 'h118),    // 17 skipped
      ei(6'h2B, 0, 1, 'h118),    // 18 skipped
      ei(6'h05, 1, 1, 4),        // 19 not taken
      ei(6'h2B, 0, 3, 'h11C),    // 20
      32'hFC00_0000,             // 21 undefined opcode
      ei(6'h0C, 2, 10, 'hFF),    // 22 r10 = r2 & 0xFF
      ei(6'h2B, 0, 10, 'h120),   // 23
      ej(26),                    // 24 jump to word 26
      ei(6'h2B, 0, 1, 'h124),    // 25 skipped
      ei(6'h2B, 0, 4, 'h128),    // 26
      ej(27)                     // 27 halt loop
   };

   // Expected memory words after the run: word index, value, requirement
   localparam int NEXP = 11;
   localparam int          EXP_IDX [NEXP] = '{64, 65, 66, 67, 68, 69, 70, 71, 72, 73, 74};
   localparam logic [31:0] EXP_VAL [NEXP] = '{32'h2, 32'h8, 32'hF5, 32'hD, 32'h1, 32'h0,
                                             32'h1111_1111, 32'h2, 32'hFD, 32'h5A5A_5A5A, 32'h8};
   // R3 add, R3 sub, R2 field positions via xor, R5 load then or, R3 slt, R9 r0,
   // R7 skipped slots, R7 fall-through, R4 sign-extended and, R8 skipped slot, R6 store
   localparam int          EXP_REQ [NEXP] = '{3, 3, 2, 5, 3, 9, 7, 7, 4, 8, 6};

   // Fetch spacing: log index, expected cycles, requirement
   localparam int NGAP = 8;
   localparam int GAP_IDX [NGAP] = '{0, 2, 4, 9, 16, 17, 19, 22};
   localparam int GAP_LEN [NGAP] = '{5, 5, 4, 5, 3, 3, 2, 3};
   // R4 addi, R3 add, R6 store, R5 load, R7 taken, R7 not taken, R10 undefined, R8 jump
   localparam int GAP_REQ [NGAP] = '{4, 3, 6, 5, 7, 7, 10, 8};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mem_init = 1'b1;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr, mem_ifetch;
   logic [31:0] mem [MWORDS];

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int nf      = 0;
   int bad_bus = 0;
   int f_addr [NLOG];
   int f_cyc  [NLOG];

   always #(PERIOD/2) clk = ~clk;

   mcc_core i_mcc_core (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_ifetch(mem_ifetch), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] image(input int i);
      if (i < NPROG) return PROG[i];
      case (i)
         69:      return 32'hDEAD_BEEF;
         70:      return 32'h1111_1111;
         73:      return 32'h5A5A_5A5A;
         default: return 32'h0;
      endcase
   endfunction

   assign mem_rdata = mem[mem_addr[9:2]];

   always @(posedge clk) begin
      if (mem_init) begin
         for (int i = 0; i < MWORDS; i++) mem[i] <= image(i);
      end else if (mem_wr) begin
         mem[mem_addr[9:2]] <= mem_wdata;
      end
   end

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (!rst) begin
         if ((mem_rd && mem_wr) || (mem_ifetch && !mem_rd)) bad_bus <= bad_bus + 1;
         if (mem_ifetch && nf < NLOG) begin
            f_addr[nf] <= int'(mem_addr);
            f_cyc[nf]  <= cyc;
            nf         <= nf + 1;
         end
      end
   end

   task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int base;
      // R11: state during reset
      repeat (2) @(posedge clk);
      #1 mem_init = 1'b0;
      @(negedge clk);
      check(11, "address during reset", mem_addr, 32'h0);
      check(11, "write strobe during reset", {31'd0, mem_wr}, 32'h0);
      check(11, "fetch marked during reset", {31'd0, mem_ifetch}, 32'h1);
      @(posedge clk);
      #1 rst = 1'b0;

      for (int k = 0; k < 3000 && nf < 26; k++) @(negedge clk);
      if (nf < 26) begin
         n_tests++;
         n_fail++;
         $display("FAIL R1 program run: actual %0d fetches expected 26", nf);
      end

      // Table of expected memory results
      for (int e = 0; e < NEXP; e++)
         check(EXP_REQ[e], $sformatf("memory word %0d", EXP_IDX[e]), mem[EXP_IDX[e]], EXP_VAL[e]);

      // Cycle counts per class from fetch spacing
      for (int g = 0; g < NGAP; g++)
         check(GAP_REQ[g], $sformatf("cycles after fetch %0d", GAP_IDX[g]),
               32'(f_cyc[GAP_IDX[g]+1] - f_cyc[GAP_IDX[g]]), 32'(GAP_LEN[g]));

      // Next-PC rules
      check(11, "first fetch after reset", 32'(f_addr[0]), 32'h0);
      check(1,  "sequential fetch", 32'(f_addr[1]), 32'h4);
      check(7,  "taken branch target", 32'(f_addr[17]), 32'h4C);
      check(7,  "not-taken branch next", 32'(f_addr[18]), 32'h50);
      check(10, "fetch after undefined", 32'(f_addr[20]), 32'h58);
      check(8,  "jump target", 32'(f_addr[23]), 32'h68);
      check(8,  "halt loop target", 32'(f_addr[25]), 32'h6C);
      check(12, "bus strobe conflicts", 32'(bad_bus), 32'h0);

      // R11: reset in the middle of execution restarts at 0
      @(posedge clk);
      #1 rst = 1'b1;
      repeat (3) @(posedge clk);
      base = nf;
      #1 rst = 1'b0;
      for (int k = 0; k < 50 && nf <= base; k++) @(negedge clk);
      @(negedge clk);
      check(11, "first fetch after mid-run reset", 32'(f_addr[base]), 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule